// File: doc/BRIEF.md
# Crossbar Target Address Decoder

This block picks the destination of one crossbar transaction. It receives the captured address, the three protection bits, the index of the requesting master and whether the access reads or writes. Every slave port owns one or more address windows. Each window is given by a base address and a size exponent in a parameter table. The decoder tests all windows at the same time. It drops any window whose slave is marked secure when the access is non-secure. It also drops any window the requesting master may not reach in that direction. The surviving window with the highest flat index is reported one clock later as a slave index and a region index.

When nothing survives, the hit flag stays low. The surrounding crossbar then routes the transaction to its decode-error responder. Arbitration, channel steering and the error responder lie outside this block.

Every window's base is checked against its size when the block is elaborated. A base with any bit set below the size exponent stops elaboration with an error and costs no hardware.

Top module: `xbar_addr_decode`

## Requirements
- R1: A window with size exponent W matches when the address shifted right by W equals the window base shifted right by W.
- R2: A window whose size exponent is 0 never matches, whatever the address.
- R3: Bit 1 of the protection input set to 1 marks a non-secure access. Such an access never selects a slave whose secure flag is set. Bits 0 and 2 of the protection input have no effect on the decode.
- R4: A read consults the read reach mask and a write consults the write reach mask. The bit at position master + slave*N_MST must be 1, or that slave's windows cannot match.
- R5: Each slave owns N_REG windows, and window r of slave s sits at flat index s*N_REG + r of the tables. On a hit, the output reports both s and r.
- R6: When several windows survive, the one with the highest flat index is selected.
- R7: When no window survives, the hit flag is 0 and the slave and region outputs are both 0.
- R8: Results are registered. The valid, hit, slave and region outputs seen after a rising edge describe the request present at that edge, and valid copies the request valid.
- R9: Windows with size exponents below 12 decode exactly, down to a single-byte boundary at their top address.
- R10: While reset is active, valid and hit read 0 whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | ADDR_W | Transaction address |
| req_prot | input | 3 | Protection bits; bit 1 = 1 means non-secure |
| req_mst | input | clog2(N_MST) | Index of the requesting master |
| req_is_read | input | 1 | 1 for a read, 0 for a write |
| dec_valid | output | 1 | Registered copy of req_valid |
| dec_hit | output | 1 | A window was selected |
| dec_slv | output | clog2(N_SLV) | Selected slave index, 0 on a miss |
| dec_rgn | output | clog2(N_REG) | Selected region within the slave, 0 on a miss |

## Verification
The assertions check four properties on every cycle. A hit never lands on a secure slave for a non-secure access. The reach-mask bit of the selected slave is always set. The reported window is the highest-indexed one among those that survived. A miss always drives zero indices, and valid follows the request by exactly one edge.

Some properties can only be shown by the bench's scenarios. It must show that a window really matches over its whole span and not one byte further. A zero-size window and a masked master must fall through to a lower-priority overlapping window. Protection bits 0 and 2 must leave the decode unchanged.

// File: rtl/xbar_dec_pkg.sv
package xbar_dec_pkg;

    // Width of an index able to address n items (at least one bit).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/xbar_dec_window.sv
// One address window: shifted base compare, gated by reach and security.
module xbar_dec_window #(
    parameter int              ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE  = '0,
    parameter int              WIDTH  = 0,
    parameter bit              SECURE = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              non_sec,
    input  logic              reach_ok,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LOW_MASK =
        (WIDTH >= ADDR_W) ? {ADDR_W{1'b1}} : ((ADDR_W'(1) << WIDTH) - ADDR_W'(1));

    generate
        if (WIDTH > 0 && (BASE & LOW_MASK) != '0) begin : g_align_bad
            $error("window base %h is not aligned to a 2**%0d window", BASE, WIDTH);
        end

        if (WIDTH == 0) begin : g_off
            logic addr_unused;
            assign addr_unused = ^{addr, non_sec, reach_ok};
            assign hit = 1'b0;
        end else begin : g_on
            logic in_span;
            logic sec_ok;
            assign in_span = ((addr >> WIDTH) == (BASE >> WIDTH));
            assign sec_ok  = !(SECURE && non_sec);
            assign hit     = in_span && sec_ok && reach_ok;
        end
    endgenerate
endmodule

// File: rtl/xbar_dec_pick.sv
// Selects the highest-indexed set bit of a hit vector.
module xbar_dec_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  hits,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (hits[k]) begin
                idx = IW'(k);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xbar_addr_decode.sv
module xbar_addr_decode #(
    parameter int ADDR_W = 32,
    parameter int N_SLV  = 4,
    parameter int N_REG  = 2,
    parameter int N_MST  = 2,
    parameter logic [N_SLV*N_REG*ADDR_W-1:0] REGION_BASE = {
        32'h0000_0000, 32'h0002_0000, 32'h0000_1000, 32'h0001_0000,
        32'h0000_2000, 32'h0000_1000, 32'h0000_8000, 32'h0000_0000},
    parameter logic [N_SLV*N_REG*32-1:0] REGION_WIDTH = {
        32'd0, 32'd16, 32'd4, 32'd16, 32'd0, 32'd12, 32'd8, 32'd12},
    parameter logic [N_SLV-1:0]       SECURE_SLV = 4'b1000,
    parameter logic [N_SLV*N_MST-1:0] RD_CONN    = 8'hEF,
    parameter logic [N_SLV*N_MST-1:0] WR_CONN    = 8'hF7
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    input  logic [ADDR_W-1:0]                      req_addr,
    input  logic [2:0]                             req_prot,
    input  logic [xbar_dec_pkg::idx_w(N_MST)-1:0]  req_mst,
    input  logic                                   req_is_read,
    output logic                                   dec_valid,
    output logic                                   dec_hit,
    output logic [xbar_dec_pkg::idx_w(N_SLV)-1:0]  dec_slv,
    output logic [xbar_dec_pkg::idx_w(N_REG)-1:0]  dec_rgn
);
    localparam int N_TOT = N_SLV * N_REG;
    localparam int SLV_W = xbar_dec_pkg::idx_w(N_SLV);
    localparam int RGN_W = xbar_dec_pkg::idx_w(N_REG);
    localparam int MST_W = xbar_dec_pkg::idx_w(N_MST);
    localparam int TOT_W = xbar_dec_pkg::idx_w(N_TOT);

    typedef struct packed {
        logic             vld;
        logic             hit;
        logic [SLV_W-1:0] slv;
        logic [RGN_W-1:0] rgn;
    } dec_st_t;

    dec_st_t dec_d, dec_q;

    logic [N_SLV-1:0] reach_vec;
    logic [N_TOT-1:0] hit_vec;
    logic [TOT_W-1:0] pick_idx;
    logic             pick_any;
    logic             prot_unused;

    assign prot_unused = ^{req_prot[2], req_prot[0]};

    // Per-slave reach check, then per-window compare.
    generate
        for (genvar s = 0; s < N_SLV; s++) begin : g_slv
            logic [N_MST-1:0] rd_row, wr_row;
            assign rd_row       = RD_CONN[s*N_MST +: N_MST];
            assign wr_row       = WR_CONN[s*N_MST +: N_MST];
            assign reach_vec[s] = req_is_read ? rd_row[req_mst] : wr_row[req_mst];

            for (genvar r = 0; r < N_REG; r++) begin : g_rgn
                localparam int K = s * N_REG + r;
                xbar_dec_window #(
                    .ADDR_W (ADDR_W),
                    .BASE   (REGION_BASE[K*ADDR_W +: ADDR_W]),
                    .WIDTH  (int'(REGION_WIDTH[K*32 +: 32])),
                    .SECURE (SECURE_SLV[s])
                ) u_win (
                    .addr     (req_addr),
                    .non_sec  (req_prot[1]),
                    .reach_ok (reach_vec[s]),
                    .hit      (hit_vec[K])
                );
            end
        end
    endgenerate

    xbar_dec_pick #(
        .N  (N_TOT),
        .IW (TOT_W)
    ) u_pick (
        .hits (hit_vec),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    always_comb begin
        dec_d     = '0;
        dec_d.vld = req_valid;
        if (req_valid && pick_any) begin
            dec_d.hit = 1'b1;
            dec_d.slv = SLV_W'(int'(pick_idx) / N_REG);
            dec_d.rgn = RGN_W'(int'(pick_idx) % N_REG);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec_valid = dec_q.vld;
    assign dec_hit   = dec_q.hit;
    assign dec_slv   = dec_q.slv;
    assign dec_rgn   = dec_q.rgn;

    // ---------------- assertions ----------------
    function automatic logic reach_bit(input logic rd, input logic [MST_W-1:0] m,
                                       input logic [SLV_W-1:0] s);
        int b;
        b = int'(m) + int'(s) * N_MST;
        return rd ? RD_CONN[b] : WR_CONN[b];
    endfunction

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);                                              // R8
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dec_valid && !dec_hit);                                // R8
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !dec_hit |-> dec_slv == '0 && dec_rgn == '0);             // R7
    AST_SECURE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit && $past(req_prot[1]) |-> !SECURE_SLV[dec_slv]);               // R3
    AST_REACH_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> reach_bit($past(req_is_read), $past(req_mst), dec_slv));   // R4
    AST_TOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> ($past(hit_vec) >> (int'(dec_slv) * N_REG + int'(dec_rgn)))
                    == N_TOT'(1));                                             // R6
endmodule

// File: tb/xbar_addr_decode_tb.sv
module xbar_addr_decode_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [2:0]  req_prot;
    logic [0:0]  req_mst;
    logic        req_is_read;
    logic        dec_valid, dec_hit;
    logic [1:0]  dec_slv;
    logic [0:0]  dec_rgn;

    always #2.5 clk = ~clk;   // 200 MHz

    xbar_addr_decode dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_prot(req_prot), .req_mst(req_mst), .req_is_read(req_is_read),
        .dec_valid(dec_valid), .dec_hit(dec_hit), .dec_slv(dec_slv), .dec_rgn(dec_rgn)
    );

    // Reference configuration, same meaning as the default parameters.
    int unsigned base_t [8] = '{32'h0000_0000, 32'h0000_8000, 32'h0000_1000, 32'h0000_2000,
                                32'h0001_0000, 32'h0000_1000, 32'h0002_0000, 32'h0000_0000};
    int          width_t[8] = '{12, 8, 12, 0, 16, 4, 16, 0};
    bit          secure_t[4] = '{0, 0, 0, 1};
    bit [7:0]    rd_mask = 8'hEF;
    bit [7:0]    wr_mask = 8'hF7;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Pending expectation for the request applied before the next edge.
    bit    e_valid, e_hit;
    int    e_slv, e_rgn;
    string e_tag;
    bit    have_exp = 1'b0;

    task automatic model(input bit v, input int unsigned a, input bit [2:0] p,
                         input int m, input bit rd, input string tag);
        int best;
        best = -1;
        for (int k = 0; k < 8; k++) begin
            int s;
            bit reach;
            s = k / 2;
            reach = rd ? rd_mask[m + s*2] : wr_mask[m + s*2];
            if (width_t[k] != 0 && (a >> width_t[k]) == (base_t[k] >> width_t[k])
                && !(secure_t[s] && p[1]) && reach)
                best = k;   // later windows override earlier ones
        end
        e_valid  = v;
        e_hit    = v && (best >= 0);
        e_slv    = e_hit ? best / 2 : 0;
        e_rgn    = e_hit ? best % 2 : 0;
        e_tag    = tag;
        have_exp = 1'b1;
    endtask

    task automatic compare();
        if (!have_exp) return;
        checks++;
        if (dec_valid !== e_valid || dec_hit !== e_hit ||
            int'(dec_slv) != e_slv || int'(dec_rgn) != e_rgn) begin
            errors++;
            $display("FAIL %s: got v=%0b h=%0b s=%0d r=%0d exp v=%0b h=%0b s=%0d r=%0d",
                     e_tag, dec_valid, dec_hit, dec_slv, dec_rgn,
                     e_valid, e_hit, e_slv, e_rgn);
        end
    endtask

    task automatic step(input bit v, input int unsigned a, input bit [2:0] p,
                        input int m, input bit rd, input string tag);
        @(negedge clk);
        compare();
        req_valid   = v;
        req_addr    = a;
        req_prot    = p;
        req_mst     = 1'(m);
        req_is_read = rd;
        model(v, a, p, m, rd, tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b1; req_addr = 32'h0; req_prot = 3'b000;
        req_mst = 1'b0; req_is_read = 1'b1;
        // R10: reset holds outputs low although a matching request is offered
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (dec_valid !== 1'b0 || dec_hit !== 1'b0) begin
                errors++;
                $display("FAIL R10: got v=%0b h=%0b exp v=0 h=0", dec_valid, dec_hit);
            end
        end
        rst_n = 1'b1;
        req_valid = 1'b0;
        model(1'b0, 0, 3'b000, 0, 1'b1, "R8");

        step(1, 32'h0000_0ABC, 3'b000, 0, 1, "R1");    // s0 r0
        step(1, 32'h0000_0FFF, 3'b000, 1, 0, "R1");    // top byte of s0 r0
        step(0, 32'h0000_0ABC, 3'b000, 0, 1, "R8");    // idle request
        step(1, 32'h0000_1000, 3'b000, 1, 1, "R6");    // overlap: s2 r1 beats s1 r0
        step(1, 32'h0000_1000, 3'b000, 0, 1, "R4");    // m0 may not read s2 -> s1 r0
        step(1, 32'h0000_100F, 3'b000, 1, 1, "R9");    // last byte of 16-byte window
        step(1, 32'h0000_1010, 3'b000, 1, 1, "R9");    // just beyond -> s1 r0
        step(1, 32'h0000_80FF, 3'b000, 0, 1, "R5");    // s0 r1
        step(1, 32'h0000_8100, 3'b000, 0, 1, "R7");    // miss
        step(1, 32'h0000_2004, 3'b000, 0, 1, "R2");    // zero-size window
        step(1, 32'h0000_0000, 3'b000, 0, 1, "R2");    // base of zero-size s3 r1 -> s0 r0
        step(1, 32'h0002_1234, 3'b000, 0, 1, "R3");    // secure access to s3
        step(1, 32'h0002_1234, 3'b010, 0, 1, "R3");    // non-secure blocked
        step(1, 32'h0002_1234, 3'b101, 0, 1, "R3");    // bits 0 and 2 ignored
        step(1, 32'h0000_1800, 3'b000, 1, 0, "R4");    // m1 may not write s1
        step(1, 32'h0000_1800, 3'b000, 0, 0, "R4");    // m0 write ok
        step(1, 32'h0001_FFFF, 3'b000, 0, 0, "R4");    // m0 write to s2 ok
        step(1, 32'h0001_FFFF, 3'b000, 0, 1, "R4");    // m0 read to s2 blocked
        step(1, 32'h0002_0000, 3'b000, 1, 1, "R5");    // s3 r0

        for (int i = 0; i < 400; i++) begin
            int unsigned a;
            int sel;
            sel = $urandom % 4;
            case (sel)
                0: a = $urandom & 32'h0000_FFFF;
                1: a = 32'h0000_8000 | ($urandom & 32'h1FF);
                2: a = 32'h0001_0000 | ($urandom & 32'h1_FFFF);
                default: a = 32'h0000_1000 | ($urandom & 32'h1F);
            endcase
            step(($urandom % 8) != 0, a, 3'($urandom), $urandom % 2, 1'($urandom), "R1");
        end
        @(negedge clk);
        compare();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running exp finished");
            finish_run();
        end
    end
endmodule